// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block paces the accesses a requester makes to several external devices that share one data bus. The top two address bits pick one of four device regions. For the chosen region the block drives a chip select and either a read strobe or a write strobe. Each region's strobes are held for a number of extra wait cycles that is programmed per region. The requester learns that the access is over through a one-cycle done pulse.

Some devices keep driving the shared bus for a while after they are deselected, and longer strobes do not help with that. Each region therefore also has a recovery count. After an access to a region with a non-zero recovery count, the block keeps every select and strobe off for that many cycles before it accepts the next request. The recovery gap depends only on the region that was just accessed, so a following access to a fast region is not made longer. A request that arrives during recovery waits until the gap is over.

The controller is a four-state machine:
- `ST_IDLE`: waits for a request.
- `ST_ASSERT`: the first strobe cycle.
- `ST_STRETCH`: the wait cycles.
- `ST_RECOVER`: post-access idle time.

Its transitions are:
- idle to assert, when a request is accepted.
- assert to stretch, when the wait count is non-zero.
- assert or stretch to recover, at completion when the recovery count is non-zero.
- assert or stretch to idle, at completion when the recovery count is zero.
- recover to idle, when the recovery count runs out.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset, no select, strobe or done is active, and every region's configuration reads as wait = 15 and recovery = 3.
- R2: Address bits [AW-1:AW-2] give the region number n, and only `cs_o[n]` is driven during that access.
- R3: For a region with wait count W (0..15), its select and strobe stay high for exactly 1+W consecutive cycles.
- R4: `done_o` is a single-cycle pulse, given in the last strobe cycle of each access.
- R5: A read (`req_we_i`=0) drives `oe_o` and a write (`req_we_i`=1) drives `we_o`; the two are never high together.
- R6: With recovery count P (0..3) on the region just accessed, all selects stay off for P+1 cycles after the done cycle. A request held during that time starts its select in the cycle after.
- R7: The recovery gap depends only on the previous access's region; the next access's strobe length follows only its own region's wait count.
- R8: `oe_o` and `we_o` are low in every cycle that has no select active, including recovery cycles.
- R9: A configuration write (`cfg_we_i`, region `cfg_idx_i`) is used by requests accepted after the write; an access already in progress keeps the wait and recovery it was accepted with.
- R10: A request raised while the controller is idle is accepted at the next clock edge, and its select is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until done |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Access address; the top two bits pick the region |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 2 | Region whose configuration is written |
| cfg_wait_i | input | 4 | New wait count |
| cfg_post_i | input | 2 | New recovery count |
| done_o | output | 1 | One-cycle completion pulse |
| cs_o | output | 4 | Per-region chip selects, active high |
| oe_o | output | 1 | Read (output enable) strobe |
| we_o | output | 1 | Write strobe |

## Verification
The assertions take for granted that the requester keeps `req_i`, `req_we_i` and `req_addr_i` steady from the moment it raises the request until it sees `done_o`. They also take for granted that a configuration write lasts exactly one cycle. The stimulus changes inputs only on falling clock edges. It releases or replaces a request in the same cycle as the done pulse, and it issues configuration writes either while the controller is idle or during the first strobe cycle of a multi-cycle access, which is what tests that the settings locked at acceptance are kept.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int WAIT_W = 4;
    localparam int POST_W = 2;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic [POST_W-1:0] post;
    } xb_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_STRETCH,
        ST_RECOVER
    } xb_state_t;

endpackage

// File: rtl/xbus_region_dec.sv
module xbus_region_dec #(
    parameter int AW = 16,
    parameter int RB = 2
) (
    input  logic [AW-1:0] addr_i,
    output logic [RB-1:0] region_o
);
    always_comb begin
        region_o = addr_i[AW-1 -: RB];
    end
endmodule

// File: rtl/xbus_cfg_bank.sv
module xbus_cfg_bank
    import xbus_pkg::*;
#(
    parameter int RB = 2,
    localparam int NREG = 1 << RB
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [RB-1:0]     wr_idx_i,
    input  xb_cfg_t           wr_data_i,
    output xb_cfg_t           cfg_o [NREG]
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                cfg_o[g].waits <= '1;
                cfg_o[g].post  <= '1;
            end else if (wr_i && (wr_idx_i == RB'(g))) begin
                cfg_o[g] <= wr_data_i;
            end
        end
    end
endmodule

// File: rtl/xbus_phase_cnt.sv
module xbus_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         is_zero_o,
    output logic         is_one_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    always_comb begin
        is_zero_o = (cnt_q == '0);
        is_one_o  = (cnt_q == W'(1));
    end
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int RB = 2,
    localparam int NREG = 1 << RB,
    localparam int CNT_W = (WAIT_W > POST_W) ? WAIT_W : POST_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [AW-1:0]     req_addr_i,
    input  logic              cfg_we_i,
    input  logic [RB-1:0]     cfg_idx_i,
    input  logic [WAIT_W-1:0] cfg_wait_i,
    input  logic [POST_W-1:0] cfg_post_i,
    output logic              done_o,
    output logic [NREG-1:0]   cs_o,
    output logic              oe_o,
    output logic              we_o
);
    xb_state_t         state_q, state_d;
    logic [RB-1:0]     req_region;
    logic [RB-1:0]     cur_region;
    logic              cur_we;
    logic [POST_W-1:0] cur_post;
    xb_cfg_t           cfg_all [NREG];
    xb_cfg_t           cfg_wr;
    xb_cfg_t           cfg_sel;
    logic              cnt_load, cnt_dec, cnt_zero, cnt_one, finish;
    logic [CNT_W-1:0]  cnt_val;
    logic [NREG-1:0]   sel_vec;
    logic              accept;

    xbus_region_dec #(.AW(AW), .RB(RB)) u_dec (
        .addr_i   (req_addr_i),
        .region_o (req_region)
    );

    always_comb begin
        cfg_wr.waits = cfg_wait_i;
        cfg_wr.post  = cfg_post_i;
    end

    xbus_cfg_bank #(.RB(RB)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (cfg_we_i),
        .wr_idx_i  (cfg_idx_i),
        .wr_data_i (cfg_wr),
        .cfg_o     (cfg_all)
    );

    xbus_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .dec_i      (cnt_dec),
        .is_zero_o  (cnt_zero),
        .is_one_o   (cnt_one)
    );

    always_comb begin
        cfg_sel = cfg_all[req_region];
        accept  = (state_q == ST_IDLE) && req_i;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel_vec[g] = (cur_region == RB'(g));
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Access context captured at acceptance
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_region <= '0;
            cur_we     <= 1'b0;
            cur_post   <= '0;
        end else if (accept) begin
            cur_region <= req_region;
            cur_we     <= req_we_i;
            cur_post   <= cfg_sel.post;
        end
    end

    // Next state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d  = ST_ASSERT;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(cfg_sel.waits);
                end
            end
            ST_ASSERT: begin
                if (cnt_zero) finish = 1'b1;
                else          state_d = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (cnt_one) finish = 1'b1;
                else         cnt_dec = 1'b1;
            end
            ST_RECOVER: begin
                if (cnt_one) state_d = ST_IDLE;
                else         cnt_dec = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
        if (finish) begin
            if (cur_post != '0) begin
                state_d  = ST_RECOVER;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(cur_post);
            end else begin
                state_d  = ST_IDLE;
            end
        end
    end

    // Outputs
    always_comb begin
        cs_o   = '0;
        oe_o   = 1'b0;
        we_o   = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RECOVER: begin
            end
            ST_ASSERT: begin
                cs_o   = sel_vec;
                oe_o   = !cur_we;
                we_o   = cur_we;
                done_o = cnt_zero;
            end
            ST_STRETCH: begin
                cs_o   = sel_vec;
                oe_o   = !cur_we;
                we_o   = cur_we;
                done_o = cnt_one;
            end
            default: begin
            end
        endcase
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(oe_o && we_o));

    // R2
    one_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(cs_o));

    // R4
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8
    recover_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RECOVER) |-> (cs_o == '0 && !oe_o && !we_o));

    // R3
    stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STRETCH) |-> $stable(cs_o));

    // R6
    recover_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && cur_post == '0) |=> (state_q == ST_IDLE));

endmodule

// File: tb/xbus_wait_ctrl_tb_top.sv
module xbus_wait_ctrl_tb_top;
    import xbus_pkg::*;

    localparam int AW = 16;
    localparam int RB = 2;
    localparam int NR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic cfg_we = 1'b0;
    logic [RB-1:0] cfg_idx = '0;
    logic [WAIT_W-1:0] cfg_wait = '0;
    logic [POST_W-1:0] cfg_post = '0;
    logic done;
    logic [NR-1:0] cs;
    logic oe, we;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5ns clk = ~clk;

    xbus_wait_ctrl #(.AW(AW), .RB(RB)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we),
        .req_addr_i(req_addr), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
        .cfg_wait_i(cfg_wait), .cfg_post_i(cfg_post), .done_o(done),
        .cs_o(cs), .oe_o(oe), .we_o(we)
    );

    // Behavioural reference: remaining strobe cycles, remaining recovery cycles
    int m_str = 0, m_idle = 0, m_reg = 0, m_post_acc = 0;
    bit m_we = 1'b0;
    int m_wait [NR];
    int m_post [NR];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_str = 0;
            m_idle = 0;
            for (int i = 0; i < NR; i++) begin
                m_wait[i] = 15;
                m_post[i] = 3;
            end
        end else begin
            if (m_str > 0) begin
                m_str--;
                if (m_str == 0) m_idle = m_post_acc;
            end else if (m_idle > 0) begin
                m_idle--;
            end else if (req) begin
                m_reg = int'(req_addr[AW-1 -: RB]);
                m_we = req_we;
                m_str = 1 + m_wait[m_reg];
                m_post_acc = m_post[m_reg];
            end
            if (cfg_we) begin
                m_wait[cfg_idx] = int'(cfg_wait);
                m_post[cfg_idx] = int'(cfg_post);
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int exp_cs;
            bit quiet;
            quiet = (m_str == 0);
            exp_cs = quiet ? 0 : (1 << m_reg);
            check(quiet ? "R8" : "R2", "cs", int'(cs), exp_cs);
            check(quiet ? "R8" : "R5", "oe", int'(oe), (!quiet && !m_we) ? 1 : 0);
            check(quiet ? "R8" : "R5", "we", int'(we), (!quiet && m_we) ? 1 : 0);
            check("R4", "done", int'(done), (m_str == 1) ? 1 : 0);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input int idx, input int w, input int p);
        cfg_we = 1'b1;
        cfg_idx = RB'(idx);
        cfg_wait = WAIT_W'(w);
        cfg_post = POST_W'(p);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Raises a request and counts falling edges until done; leaves the bench at the done cycle
    task automatic access(input int rg, input bit w, input int exp_lat, input string tag,
                          input bit cw = 1'b0, input int ci = 0, input int cwv = 0, input int cpv = 0);
        int lat;
        req = 1'b1;
        req_we = w;
        req_addr = AW'((rg << (AW - RB)) | 'h2a5);
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (lat == 2) cfg_we = 1'b0;
            if (cw && lat == 1) begin
                cfg_we = 1'b1;
                cfg_idx = RB'(ci);
                cfg_wait = WAIT_W'(cwv);
                cfg_post = POST_W'(cpv);
            end
            if (done || lat > 300) break;
        end
        cfg_we = 1'b0;
        req = 1'b0;
        check(tag, "latency", lat, exp_lat);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "cs in reset", int'(cs), 0);
        check("R1", "strobes in reset", int'(oe) + int'(we), 0);
        check("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        // R1 R3 default wait 15 from idle
        access(0, 1'b0, 16, "R1");
        idle(6);
        cfg_write(0, 0, 0);
        cfg_write(1, 2, 3);
        cfg_write(2, 5, 1);
        cfg_write(3, 1, 2);
        idle(2);
        // R3 R10: from idle, 1+W
        access(1, 1'b0, 3, "R10");
        idle(6);
        access(1, 1'b1, 3, "R3");
        // R6 R7: P_prev + 2 + W_new
        access(0, 1'b0, 5, "R6");
        access(0, 1'b1, 2, "R6");
        access(2, 1'b0, 7, "R7");
        access(3, 1'b1, 4, "R7");
        access(2, 1'b1, 9, "R3");
        idle(6);
        // R9: reconfigure region 3 during its own access
        access(3, 1'b0, 2, "R9", 1'b1, 3, 4, 0);
        access(3, 1'b0, 8, "R9");
        access(3, 1'b1, 6, "R9");
        idle(8);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule